// File: doc/BRIEF.md
# Event Channel Enable Controller

This block keeps one enable bit per event-routing channel and lets whole sets of channels be switched on or off in a single step. Software reaches it through a simple synchronous register port. Dedicated set and clear registers change single channels. Six group masks name sets of channels. Each group has an enable task and a disable task. Writing the value 1 to a task address fires that task once.

Each task also has a subscribe register. This register names one channel and carries an enable flag. A pulse on that channel fires the task in hardware, with no software action, provided the channel itself is enabled. The enable vector is driven straight out as `ch_enable`, so neighbouring routing logic can gate its event paths with it.

The controller is reset synchronously with an active-high `rst`. Read data appears on `rsp_rdata` one cycle after the read request and holds until the next read.

Top module: `evc_ctrl`

## Requirements
- R1: A synchronous reset clears every channel enable, every group mask and every subscribe register.
- R2: A read of byte address 0x100 returns the enable vector, where bit n is 1 when channel n is enabled. Read data is valid on `rsp_rdata` in the cycle after the request.
- R3: A write to 0x104 enables each channel whose data bit is 1 and leaves channels with a 0 bit unchanged.
- R4: A write to 0x108 disables each channel whose data bit is 1, so writing all ones disables every channel.
- R5: Group g has a read/write membership mask at 0x200 + 4*g. Bit n set places channel n in the group, and the value 0 empties the group.
- R6: Task t sits at byte address 4*t. Task 2*g enables group g and task 2*g+1 disables it. Only a write of the exact value 1 fires a task, and a task address always reads 0.
- R7: A fired enable task ORs its group mask into the enable vector, and a fired disable task clears the mask bits from it. Either change is visible at the clock edge that samples the strobe.
- R8: The subscribe register of task t sits at 4*t + 0x80. Bits [4:0] hold a channel number and bit 31 enables the subscription. The register reads back as written, and writing 0 removes the subscription.
- R9: A pulse on the subscribed channel fires the task exactly as a software write of 1 would. This happens only when the subscription is enabled and that channel is currently enabled.
- R10: If enabling and disabling actions (set write, clear write, enable task, disable task) reach the same channel in the same cycle, the disabling action wins.
- R11: A misaligned or unmapped address reads 0, and a write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 12 | Byte address of the access |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid the cycle after a read request |
| evt_pulse | input | 32 | One pulse bit per incoming channel event |
| ch_enable | output | 32 | Current channel enable vector |

## Verification
A corrupted enable bit shows on `ch_enable` at the next falling edge after the edge that wrote it, so every write and event is followed by a direct compare of that vector. A wrong group mask or subscribe register stays hidden until a task uses it. For that reason each mask and each subscription is read back through the register port, one cycle after the request, and is also exercised by firing its task. Same-cycle collisions between a software write and a subscribed event are driven on purpose, so that a reversed priority shows up as a wrong channel on the following edge.

// File: rtl/evc_pkg.sv
package evc_pkg;

    // Address layout shared by decode and the bench-visible map
    localparam int ADDR_W      = 12;
    localparam int TASK_BASE   = 'h000;
    localparam int SUB_OFS     = 'h080;
    localparam int STATUS_ADDR = 'h100;
    localparam int SET_ADDR    = 'h104;
    localparam int CLR_ADDR    = 'h108;
    localparam int MASK_BASE   = 'h200;
    localparam int SUB_EN_BIT  = 31;
    localparam int IDX_W       = $clog2(SUB_OFS / 4);

    typedef enum logic [2:0] {
        RK_NONE,
        RK_TASK,
        RK_SUB,
        RK_STATUS,
        RK_SET,
        RK_CLR,
        RK_MASK
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e          kind;
        logic [IDX_W-1:0]   idx;
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int n_tasks,
                                             input int n_groups);
        reg_sel_t s;
        int ai;
        ai     = int'(a);
        s.kind = RK_NONE;
        s.idx  = '0;
        if (a[1:0] == 2'b00) begin
            if (ai >= TASK_BASE && ai < TASK_BASE + 4 * n_tasks) begin
                s.kind = RK_TASK;
                s.idx  = IDX_W'((ai - TASK_BASE) / 4);
            end else if (ai >= TASK_BASE + SUB_OFS &&
                         ai < TASK_BASE + SUB_OFS + 4 * n_tasks) begin
                s.kind = RK_SUB;
                s.idx  = IDX_W'((ai - TASK_BASE - SUB_OFS) / 4);
            end else if (ai == STATUS_ADDR) begin
                s.kind = RK_STATUS;
            end else if (ai == SET_ADDR) begin
                s.kind = RK_SET;
            end else if (ai == CLR_ADDR) begin
                s.kind = RK_CLR;
            end else if (ai >= MASK_BASE && ai < MASK_BASE + 4 * n_groups) begin
                s.kind = RK_MASK;
                s.idx  = IDX_W'((ai - MASK_BASE) / 4);
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/evc_subscriber.sv
module evc_subscriber #(
    parameter int NUM_CH = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NUM_CH-1:0] evt_pulse,
    input  logic [NUM_CH-1:0] ch_en,
    output logic              fire,
    output logic [DATA_W-1:0] cfg_word
);
    import evc_pkg::*;

    localparam int CH_W = $clog2(NUM_CH);

    typedef struct packed {
        logic            en;
        logic [CH_W-1:0] ch;
    } sub_cfg_t;

    sub_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q.en <= wdata[SUB_EN_BIT];
            cfg_q.ch <= wdata[CH_W-1:0];
        end
    end

    logic in_range;
    assign in_range = (int'(cfg_q.ch) < NUM_CH);
    assign fire     = cfg_q.en && in_range && evt_pulse[cfg_q.ch] && ch_en[cfg_q.ch];

    always_comb begin
        cfg_word                 = '0;
        cfg_word[CH_W-1:0]       = cfg_q.ch;
        cfg_word[SUB_EN_BIT]     = cfg_q.en;
    end

    // R8
    sub_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata == '0) |=> !fire);

endmodule

// File: rtl/evc_chan_state.sv
module evc_chan_state #(
    parameter int NUM_CH     = 32,
    parameter int NUM_GROUPS = 6
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_CH-1:0]                 set_mask,
    input  logic [NUM_CH-1:0]                 clr_mask,
    input  logic [NUM_GROUPS-1:0]             grp_en,
    input  logic [NUM_GROUPS-1:0]             grp_dis,
    input  logic [NUM_GROUPS-1:0]             mask_we,
    input  logic [NUM_CH-1:0]                 mask_wdata,
    output logic [NUM_GROUPS-1:0][NUM_CH-1:0] grp_mask,
    output logic [NUM_CH-1:0]                 ch_en
);
    logic [NUM_GROUPS-1:0][NUM_CH-1:0] mask_q;
    logic [NUM_CH-1:0]                 ch_q;
    logic [NUM_CH-1:0]                 raise;
    logic [NUM_CH-1:0]                 kill;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_mask
        always_ff @(posedge clk) begin
            if (rst)
                mask_q[g] <= '0;
            else if (mask_we[g])
                mask_q[g] <= mask_wdata;
        end
    end

    always_comb begin
        raise = set_mask;
        kill  = clr_mask;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (grp_en[g])  raise = raise | mask_q[g];
            if (grp_dis[g]) kill  = kill  | mask_q[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ch_q <= '0;
        else
            ch_q <= (ch_q | raise) & ~kill;
    end

    assign grp_mask = mask_q;
    assign ch_en    = ch_q;

    // R10
    kill_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|kill) |=> ((ch_q & $past(kill)) == '0));

    // R3
    raise_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (|(raise & ~kill)) |=> ((ch_q & $past(raise & ~kill)) == $past(raise & ~kill)));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (set_mask == '0 && clr_mask == '0 && grp_en == '0 && grp_dis == '0) |=> $stable(ch_q));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (ch_q == '0 && mask_q == '0));

endmodule

// File: rtl/evc_ctrl.sv
module evc_ctrl #(
    parameter int NUM_CH     = 32,
    parameter int NUM_GROUPS = 6,
    parameter int DATA_W     = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [evc_pkg::ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic [DATA_W-1:0]         rsp_rdata,
    input  logic [NUM_CH-1:0]         evt_pulse,
    output logic [NUM_CH-1:0]         ch_enable
);
    import evc_pkg::*;

    localparam int NUM_TASKS = 2 * NUM_GROUPS;

    reg_sel_t sel;
    logic     wr_go;
    logic     rd_go;

    assign sel   = decode_addr(req_addr, NUM_TASKS, NUM_GROUPS);
    assign wr_go = req_valid && req_write;
    assign rd_go = req_valid && !req_write;

    // Task strobes: software writes of value 1 merged with subscribed events
    logic [NUM_TASKS-1:0]             sw_task;
    logic [NUM_TASKS-1:0]             hw_task;
    logic [NUM_TASKS-1:0]             task_fire;
    logic [NUM_TASKS-1:0]             sub_we;
    logic [NUM_TASKS-1:0][DATA_W-1:0] sub_word;
    logic [NUM_GROUPS-1:0]            grp_en;
    logic [NUM_GROUPS-1:0]            grp_dis;
    logic [NUM_GROUPS-1:0]            mask_we;
    logic [NUM_GROUPS-1:0][NUM_CH-1:0] grp_mask;
    logic [NUM_CH-1:0]                set_mask;
    logic [NUM_CH-1:0]                clr_mask;
    logic [NUM_CH-1:0]                ch_en;

    for (genvar t = 0; t < NUM_TASKS; t++) begin : g_task
        assign sw_task[t] = wr_go && sel.kind == RK_TASK && int'(sel.idx) == t &&
                            req_wdata == DATA_W'(1);
        assign sub_we[t]  = wr_go && sel.kind == RK_SUB && int'(sel.idx) == t;

        evc_subscriber #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_sub (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (sub_we[t]),
            .wdata     (req_wdata),
            .evt_pulse (evt_pulse),
            .ch_en     (ch_en),
            .fire      (hw_task[t]),
            .cfg_word  (sub_word[t])
        );

        assign task_fire[t] = sw_task[t] | hw_task[t];
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign grp_en[g]  = task_fire[2*g];
        assign grp_dis[g] = task_fire[2*g+1];
        assign mask_we[g] = wr_go && sel.kind == RK_MASK && int'(sel.idx) == g;
    end

    assign set_mask = (wr_go && sel.kind == RK_SET) ? req_wdata[NUM_CH-1:0] : '0;
    assign clr_mask = (wr_go && sel.kind == RK_CLR) ? req_wdata[NUM_CH-1:0] : '0;

    evc_chan_state #(.NUM_CH(NUM_CH), .NUM_GROUPS(NUM_GROUPS)) u_state (
        .clk        (clk),
        .rst        (rst),
        .set_mask   (set_mask),
        .clr_mask   (clr_mask),
        .grp_en     (grp_en),
        .grp_dis    (grp_dis),
        .mask_we    (mask_we),
        .mask_wdata (req_wdata[NUM_CH-1:0]),
        .grp_mask   (grp_mask),
        .ch_en      (ch_en)
    );

    assign ch_enable = ch_en;

    // Read path, one register stage
    logic [DATA_W-1:0] rd_next;
    always_comb begin
        rd_next = '0;
        unique case (sel.kind)
            RK_STATUS, RK_SET, RK_CLR: rd_next = DATA_W'(ch_en);
            RK_SUB:  rd_next = sub_word[sel.idx];
            RK_MASK: rd_next = DATA_W'(grp_mask[sel.idx]);
            default: rd_next = '0;
        endcase
    end

    logic zero_rd_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_rdata <= '0;
            zero_rd_q <= 1'b0;
        end else begin
            zero_rd_q <= rd_go && (sel.kind == RK_TASK || sel.kind == RK_NONE);
            if (rd_go)
                rsp_rdata <= rd_next;
        end
    end

    // R6 R11
    zero_read_chk: assert property (@(posedge clk) disable iff (rst)
        zero_rd_q |-> (rsp_rdata == '0));

    // R11
    dead_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_go && sel.kind == RK_NONE && hw_task == '0) |=> $stable(ch_enable));

endmodule

// File: tb/tb_evc_ctrl.sv
module tb_evc_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_write;
    logic [11:0] req_addr;
    logic [31:0] req_wdata;
    logic [31:0] rsp_rdata;
    logic [31:0] evt_pulse;
    logic [31:0] ch_enable;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    evc_ctrl dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_rdata (rsp_rdata),
        .evt_pulse (evt_pulse),
        .ch_enable (ch_enable)
    );

    // Scoreboard: expected read items queued by the driver
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_flag = 1'b0;

    always @(posedge clk) rd_flag <= req_valid && !req_write && !rst;

    always @(negedge clk) begin
        if (rd_flag) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL scoreboard: unexpected read actual=%h expected=none", rsp_rdata);
            end else begin
                logic [31:0] e;
                string       tg;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                if (rsp_rdata !== e) begin
                    failures++;
                    $display("FAIL %s: read actual=%h expected=%h", tg, rsp_rdata, e);
                end
            end
        end
    end

    task automatic wr_evt(input logic [11:0] a, input logic [31:0] d, input logic [31:0] ev);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; evt_pulse = ev;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; evt_pulse = '0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        wr_evt(a, d, 32'h0);
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tg);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tg);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pulse(input logic [31:0] m);
        @(negedge clk);
        evt_pulse = m;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic check_en(input logic [31:0] e, input string tg);
        checks++;
        if (ch_enable !== e) begin
            failures++;
            $display("FAIL %s: ch_enable actual=%h expected=%h", tg, ch_enable, e);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run hung actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0; evt_pulse = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check_en(32'h0, "R1");
        rd(12'h100, 32'h0, "R1 status");
        rd(12'h200, 32'h0, "R1 mask0");
        rd(12'h080, 32'h0, "R1 sub0");

        // R3 set, R2 status read
        wr(12'h104, 32'h0000_00F0); check_en(32'h0000_00F0, "R3");
        wr(12'h104, 32'h0000_0003); check_en(32'h0000_00F3, "R3 zeros unchanged");
        rd(12'h100, 32'h0000_00F3, "R2");

        // R4 clear
        wr(12'h108, 32'h0000_0010); check_en(32'h0000_00E3, "R4");

        // R5 group masks
        wr(12'h200, 32'h0000_FF00);
        wr(12'h204, 32'h0F00_0000);
        wr(12'h214, 32'h8000_0001);
        rd(12'h200, 32'h0000_FF00, "R5 mask0");
        rd(12'h214, 32'h8000_0001, "R5 mask5");

        // R7 group enable, R6 value other than 1 ignored
        wr(12'h000, 32'h1); check_en(32'h0000_FFE3, "R7 grp0 en");
        wr(12'h008, 32'h2); check_en(32'h0000_FFE3, "R6 value 2 ignored");
        wr(12'h008, 32'h1); check_en(32'h0F00_FFE3, "R7 grp1 en");
        rd(12'h008, 32'h0, "R6 task reads 0");
        wr(12'h004, 32'h1); check_en(32'h0F00_00E3, "R7 grp0 dis");
        wr(12'h00C, 32'h1); check_en(32'h0000_00E3, "R7 grp1 dis");
        wr(12'h028, 32'h1); check_en(32'h8000_00E3, "R7 grp5 en");

        // R8 subscribe register readback
        wr(12'h084, 32'h8000_0005);
        rd(12'h084, 32'h8000_0005, "R8 readback");

        // R10 software enable vs subscribed disable in one cycle
        wr_evt(12'h000, 32'h1, 32'h0000_0020);
        check_en(32'h8000_00E3, "R10 task collision");

        // R9 subscribed event fires enable task
        wr(12'h080, 32'h8000_0007);
        pulse(32'h0000_0080); check_en(32'h8000_FFE3, "R9 event fires");

        // R9 event on a disabled channel does nothing
        wr(12'h088, 32'h8000_0004);
        pulse(32'h0000_0010); check_en(32'h8000_FFE3, "R9 channel off");

        // R8 subscription disabled
        wr(12'h080, 32'h0000_0007);
        rd(12'h080, 32'h0000_0007, "R8 en bit clear");
        wr(12'h004, 32'h1); check_en(32'h8000_00E3, "R7 sw dis");
        pulse(32'h0000_0080); check_en(32'h8000_00E3, "R8 no fire");

        // R10 set write vs subscribed group disable
        wr_evt(12'h104, 32'h0000_0F00, 32'h0000_0020);
        check_en(32'h8000_00E3, "R10 set vs dis");

        // R4 all ones
        wr(12'h108, 32'hFFFF_FFFF); check_en(32'h0, "R4 all");
        rd(12'h100, 32'h0, "R4 status");

        // R11 unmapped and misaligned
        wr(12'h300, 32'hFFFF_FFFF);
        wr(12'h105, 32'hFFFF_FFFF);
        check_en(32'h0, "R11 write ignored");
        rd(12'h300, 32'h0, "R11 read 0");

        // R5 empty group
        wr(12'h200, 32'h0);
        rd(12'h200, 32'h0, "R5 cleared");
        wr(12'h000, 32'h1); check_en(32'h0, "R5 empty grp");
        wr(12'h028, 32'h1); check_en(32'h8000_0001, "R7 grp5 again");

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        check_en(32'h0, "R1 after run");
        rd(12'h214, 32'h0, "R1 mask5");
        rd(12'h084, 32'h0, "R1 sub1");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard: pending reads actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        finish_run();
    end

endmodule